// File: doc/BRIEF.md
# Serial Transmitter with Address-Marking Idle Gap

This block sends characters in asynchronous serial form. Each character goes out as a low start bit, then the data bits least significant first, then an optional even or odd parity bit and one or two high stop bits. A one-entry holding buffer sits in front of the shift register, so the next character can be written while the current one is still shifting out.

For multi-drop links where an address is marked by a long idle gap, software can set a wake request before it queues a character. When the shift register takes that character from the buffer, the request is copied into an internal wake flag and the request bit clears itself. A set flag makes the transmitter hold the line high for exactly eleven bit times before the start bit. That is longer than the ten-bit idle threshold receivers use to spot an address character. Bit timing comes from a one-cycle `bit_tick` strobe supplied from outside the block.

Top module: `wake_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `wake_req` is 0.
- R2: A write (`wr_en` high for one cycle) makes `buf_empty` 0 from the next cycle. The load into the shift register happens on a `bit_tick` cycle and makes `buf_empty` 1 again. A new write is accepted while the previous character is still shifting.
- R3: A `wake_set` pulse makes `wake_req` 1. The load copies `wake_req` into the internal wake flag and clears `wake_req`. A request made after a load applies only to the following character.
- R4: If the copied wake flag is 1, `txd` stays 1 for exactly 11 bit times, starting at the load tick, and the start bit follows.
- R5: If the copied wake flag is 0, the start bit (`txd` 0) begins at the load tick, with no added idle.
- R6: After the start bit, the 8 data bits go out least significant bit first, one bit time each.
- R7: With `cfg_par_en` 1, one parity bit follows the data. It equals the XOR of the data bits when `cfg_par_odd` is 0 (even parity) and the inverse of that XOR when it is 1 (odd parity). With `cfg_par_en` 0, no parity bit is sent.
- R8: The frame ends with one stop bit at 1, or two when `cfg_two_stop` is 1. All configuration inputs are sampled at the load.
- R9: If the buffer is full when the last stop bit ends, the next character loads on that same tick, with no gap.
- R10: While nothing is queued, `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe marking each bit period |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| wr_en | input | 1 | Write `wr_data` into the holding buffer |
| wr_data | input | 8 | Character to send |
| wake_set | input | 1 | Mark the next loaded character as an address |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer can take a character |
| wake_req | output | 1 | Pending wake request |

## Verification
On every cycle, the assertions check four things. A load happens only on a tick and only from a full buffer. A load empties the buffer and clears the wake request unless a new write or request arrives in the same cycle. The line is high whenever the shifter is idle or in the wake gap, and the gap is entered only with the captured flag set. Only the bench's frame captures can show the exact 11-bit gap length, the bit order, the parity polarity, the stop-bit count, the gap-free back-to-back load, and a request made mid-frame taking effect one character later.

// File: rtl/wtx_pkg.sv
package wtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/wtx_holdreg.sv
module wtx_holdreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wake_set,
    input  logic          load,
    output logic [DW-1:0] buf_data,
    output logic          buf_full,
    output logic          wake_req
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          wake;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.full = 1'b0;
            hold_d.wake = 1'b0;
        end
        if (wr_en) begin
            hold_d.data = wr_data;
            hold_d.full = 1'b1;
        end
        if (wake_set) begin
            hold_d.wake = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign buf_data = hold_q.data;
    assign buf_full = hold_q.full;
    assign wake_req = hold_q.wake;

    // R2: the shifter never takes from an empty buffer
    p_load_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> buf_full);

    // R2: a load without a concurrent write leaves the buffer empty
    p_load_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> !buf_full);

    // R3: a load without a concurrent request clears the request
    p_wake_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wake_set) |=> !wake_req);

    // R3: a request is remembered
    p_wake_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_set |=> wake_req);

endmodule

// File: rtl/wtx_shifter.sv
module wtx_shifter
    import wtx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int IDLE_BITS = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          buf_full,
    input  logic [DW-1:0] buf_data,
    input  logic          wake_in,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          two_stop,
    output logic          load,
    output logic          txd
);

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam int CW = (IDLE_BITS > 1) ? $clog2(IDLE_BITS) : 1;
    localparam logic [BW-1:0] LAST_BIT  = BW'(DW - 1);
    localparam logic [CW-1:0] LAST_IDLE = CW'(IDLE_BITS - 1);

    typedef struct packed {
        tx_state_e     state;
        logic [DW-1:0] sh;
        logic [BW-1:0] bitcnt;
        logic [CW-1:0] idlecnt;
        logic          wut;
        logic          par;
        logic          par_en;
        logic          two_stop;
        logic          stop2;
        logic          txd;
    } shift_t;

    shift_t s_d, s_q;
    logic   last_stop;
    logic   take;

    assign last_stop = (s_q.state == ST_STOP) && (!s_q.two_stop || s_q.stop2);

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        if (bit_tick) begin
            case (s_q.state)
                ST_IDLE: begin
                    take = buf_full;
                end
                ST_WAKE: begin
                    if (s_q.idlecnt == LAST_IDLE) begin
                        s_d.state = ST_START;
                    end else begin
                        s_d.idlecnt = s_q.idlecnt + 1'b1;
                    end
                end
                ST_START: begin
                    s_d.state  = ST_DATA;
                    s_d.bitcnt = '0;
                end
                ST_DATA: begin
                    if (s_q.bitcnt == LAST_BIT) begin
                        s_d.state = s_q.par_en ? ST_PAR : ST_STOP;
                        s_d.stop2 = 1'b0;
                    end else begin
                        s_d.sh     = s_q.sh >> 1;
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    s_d.state = ST_STOP;
                    s_d.stop2 = 1'b0;
                end
                ST_STOP: begin
                    if (!last_stop) begin
                        s_d.stop2 = 1'b1;
                    end else if (buf_full) begin
                        take = 1'b1;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
        if (take) begin
            s_d.sh       = buf_data;
            s_d.wut      = wake_in;
            s_d.par      = (^buf_data) ^ par_odd;
            s_d.par_en   = par_en;
            s_d.two_stop = two_stop;
            s_d.idlecnt  = '0;
            s_d.state    = wake_in ? ST_WAKE : ST_START;
        end
        case (s_d.state)
            ST_START: s_d.txd = 1'b0;
            ST_DATA:  s_d.txd = s_d.sh[0];
            ST_PAR:   s_d.txd = s_d.par;
            default:  s_d.txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.txd   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign load = take;
    assign txd  = s_q.txd;

    // R2: loads occur only on a bit tick
    p_load_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> bit_tick);

    // R4: the gap is only entered with the captured flag set
    p_wake_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAKE) |-> (s_q.wut && s_q.idlecnt <= LAST_IDLE));

    // R10 and R4: line is high while idle or in the gap
    p_mark_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE || s_q.state == ST_WAKE) |-> txd);

    // R5: start state always drives a low line
    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_START) |-> !txd);

endmodule

// File: rtl/wake_uart_tx.sv
module wake_uart_tx #(
    parameter int DATA_BITS = 8,
    parameter int IDLE_BITS = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic                 cfg_two_stop,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 wake_set,
    output logic                 txd,
    output logic                 buf_empty,
    output logic                 wake_req
);

    logic [DATA_BITS-1:0] buf_data;
    logic                 buf_full;
    logic                 load;
    logic                 wake_q;

    wtx_holdreg #(.DW(DATA_BITS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wake_set (wake_set),
        .load     (load),
        .buf_data (buf_data),
        .buf_full (buf_full),
        .wake_req (wake_q)
    );

    wtx_shifter #(.DW(DATA_BITS), .IDLE_BITS(IDLE_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .wake_in  (wake_q),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .two_stop (cfg_two_stop),
        .load     (load),
        .txd      (txd)
    );

    assign buf_empty = !buf_full;
    assign wake_req  = wake_q;

endmodule

// File: tb/sim_wake_uart_tx.sv
module sim_wake_uart_tx;

    localparam int TICK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wake_set = 1'b0;
    logic       txd;
    logic       buf_empty;
    logic       wake_req;
    logic [1:0] tcnt = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    always @(posedge clk) tcnt <= tcnt + 2'd1;
    assign bit_tick = (tcnt == 2'(TICK - 1));

    wake_uart_tx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wake_set     (wake_set),
        .txd          (txd),
        .buf_empty    (buf_empty),
        .wake_req     (wake_req)
    );

    // vector: {data[7:0], wake, par_en, par_odd, two_stop}
    localparam logic [11:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h01, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h07, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'hFE, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h80, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_tick_edge();
        do @(negedge clk); while (!bit_tick);
        @(negedge clk);
    endtask

    task automatic write_char(input logic [7:0] d, input logic wk);
        wait_tick_edge();
        wr_en = 1'b1; wr_data = d; wake_set = wk;
        @(negedge clk);
        wr_en = 1'b0; wake_set = 1'b0;
    endtask

    // Capture one frame starting at the load tick; optionally queue another.
    task automatic run_frame(input logic [7:0] d, input logic wk, input logic pe,
                             input logic po, input logic ts, input string req,
                             input logic q_en, input logic [7:0] q_d, input logic q_wk);
        logic [31:0] exp_bits = '0;
        logic [31:0] got_bits = '0;
        int n = 0;
        cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
        if (wk) begin
            for (int i = 0; i < 11; i++) begin exp_bits[n] = 1'b1; n++; end
        end
        exp_bits[n] = 1'b0; n++;
        for (int i = 0; i < 8; i++) begin exp_bits[n] = d[i]; n++; end
        if (pe) begin exp_bits[n] = (^d) ^ po; n++; end
        exp_bits[n] = 1'b1; n++;
        if (ts) begin exp_bits[n] = 1'b1; n++; end
        for (int i = 0; i < n; i++) begin
            wait_tick_edge();
            got_bits[i] = txd;
            if (i == 0) begin
                check(!wake_req, "R3 request cleared at load", int'(wake_req), 0);
                check(buf_empty, "R2 empty after load", int'(buf_empty), 1);
            end
            if (i == 2 && q_en) begin
                wr_en = 1'b1; wr_data = q_d; wake_set = q_wk;
                @(negedge clk);
                wr_en = 1'b0; wake_set = 1'b0;
                check(!buf_empty, "R2 write accepted while shifting", int'(buf_empty), 0);
                if (q_wk) check(wake_req, "R3 request pending", int'(wake_req), 1);
            end
        end
        check(got_bits == exp_bits, req, int'(got_bits), int'(exp_bits));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd, "R1 txd after reset", int'(txd), 1);
        check(buf_empty, "R1 buf_empty after reset", int'(buf_empty), 1);
        check(!wake_req, "R1 wake_req after reset", int'(wake_req), 0);
        rst_n = 1'b1;

        // Table walk: R4 R5 R6 R7 R8 per vector
        for (int v = 0; v < 6; v++) begin
            write_char(VEC[v][11:4], VEC[v][3]);
            check(!buf_empty, "R2 full after write", int'(buf_empty), 0);
            run_frame(VEC[v][11:4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0],
                      "R4 R5 R6 R7 R8 frame", 1'b0, 8'h00, 1'b0);
        end

        // R10: nothing queued keeps line high
        for (int i = 0; i < 5; i++) begin
            wait_tick_edge();
            check(txd && buf_empty, "R10 idle line mark", int'(txd), 1);
        end

        // R9 back-to-back and R3 request raised mid-frame applies to next char
        write_char(8'h5A, 1'b0);
        run_frame(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, "R9 first frame unaffected by late request",
                  1'b1, 8'hC3, 1'b1);
        run_frame(8'hC3, 1'b1, 1'b1, 1'b0, 1'b0, "R9 R3 R4 queued address frame",
                  1'b1, 8'h0F, 1'b0);
        run_frame(8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, "R9 R5 gapless follow-on frame",
                  1'b0, 8'h00, 1'b0);

        wait_tick_edge();
        check(txd, "R10 idle after burst", int'(txd), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule